// File: doc/BRIEF.md
# Error-Integrating Dead-Time Compensator

This block sits in the gate-command path of one half-bridge phase, ahead of dead-time insertion. It takes the synchronized PWM command and a digitized copy of the real phase output. From these it produces a corrected command whose edges are placed so that the average output voltage follows the command, despite dead time and unequal switching delays.

A signed counter integrates the voltage error over time. Each clock it steps up when the command is high and the output is still low, and it steps down when the command is low and the output is still high. Two signed thresholds decide each edge of the corrected command:

- **Rising edge:** passed at once if the counter is at or above the turn-on threshold, otherwise held back until the counter climbs there.
- **Falling edge:** passed at once if the counter is at or below the turn-off threshold, otherwise held back until the counter drops there.

Both comparisons are made on every clock, so a held edge is released on the first cycle the threshold is met. The delay from command to output therefore stays at the larger of the two switching delays.

Short input pulses may be dropped from the output. Their error remains in the counter, and a later output pulse of about their summed width is produced. Once the counter lies above the turn-off threshold, the corrected command stays high until the output has actually turned on.

Top module: `dtc_compensator`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released with both inputs low, the counter output reads 0 and the corrected command is low.
- R2: On a clock edge where the command is 1 and the feedback is 0, the counter increases by exactly 1, unless it is already at its upper limit.
- R3: On a clock edge where the command is 0 and the feedback is 1, the counter decreases by exactly 1, unless it is already at its lower limit.
- R4: On a clock edge where the command and the feedback are equal, the counter keeps its value.
- R5: The counter is two's complement, CNT_W bits wide. It saturates at +(2^(CNT_W-1))-1 and at -(2^(CNT_W-1)) and never wraps.
- R6: On a clock edge where the command is 1 and the counter is at or above THR_ON, the corrected command is 1 after that edge.
- R7: On a clock edge where the command is 1 and the counter is below THR_ON, the corrected command keeps its present value.
- R8: On a clock edge where the command is 0 and the counter is at or below THR_OFF, the corrected command is 0 after that edge.
- R9: On a clock edge where the command is 0 and the counter is above THR_OFF, the corrected command keeps its present value. This holds the output pulse until the feedback has turned on and pulled the counter down.
- R10: The counter value used by R6 to R9 is the value before that same edge. The corrected command is registered, so it changes one clock after the edge on which its condition is met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_pwm | input | 1 | Synchronized PWM command |
| fb_pwm | input | 1 | Synchronized digitized phase-output feedback |
| gate_cmd | output | 1 | Compensated PWM command, sent on to dead-time insertion |
| err_level | output | CNT_W | Signed error-integral counter value, for debug |

## Verification
The bench builds the block with:

| Parameter | Value | Purpose |
|-----------|-------|---------|
| CNT_W | 6 | Limits of +31 and -32, reached in a few dozen cycles of held mismatch |
| THR_ON | -3 | Turn-on threshold |
| THR_OFF | 4 | Turn-off threshold |

With a 6-bit counter, both saturation limits are reached and held within a short run. Because the thresholds are unequal and on either side of zero, every branch of both edge decisions is exercised:

- held rise
- immediate rise
- held fall
- immediate fall

The bench applies direct feedback patterns, including random ones. It also drives a feedback model with a 3-cycle turn-on delay and a 5-cycle turn-off delay, and applies pulses both wider and narrower than those delays. This exercises the recovery of dropped short pulses.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Direction of the error integral for one clock.
    function automatic step_e step_of(input logic cmd, input logic fb);
        if (cmd && !fb) begin
            return STEP_UP;
        end
        if (!cmd && fb) begin
            return STEP_DOWN;
        end
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/dtc_error_integrator.sv
module dtc_error_integrator
    import dtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd,
    input  logic                    fb,
    output logic signed [CNT_W-1:0] cnt
);

    localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
    } integ_state_t;

    integ_state_t st_d, st_q;
    step_e        step;

    always_comb begin
        st_d = st_q;
        step = step_of(cmd, fb);
        unique case (step)
            STEP_UP: begin
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            STEP_DOWN: begin
                if (st_q.cnt != CNT_MIN) begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
            default: begin
                st_d.cnt = st_q.cnt;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R2: count up by one below the upper limit
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && !fb && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

    // R3: count down by one above the lower limit
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd && fb && cnt != CNT_MIN) |=> (cnt == $past(cnt) - CNT_ONE));

    // R4: equal inputs freeze the integral
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == fb) |=> $stable(cnt));

    // R5: saturation at both limits
    p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && !fb && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd && fb && cnt == CNT_MIN) |=> (cnt == CNT_MIN));

endmodule

// File: rtl/dtc_edge_gate.sv
module dtc_edge_gate #(
    parameter int          CNT_W   = 16,
    parameter int signed   THR_ON  = 0,
    parameter int signed   THR_OFF = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd,
    input  logic signed [CNT_W-1:0] cnt,
    output logic                    drv
);

    typedef struct packed {
        logic drv;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        rise_ok;
    logic        fall_ok;

    always_comb begin
        rise_ok = (int'(cnt) >= THR_ON);
        fall_ok = (int'(cnt) <= THR_OFF);
        st_d    = st_q;
        if (cmd) begin
            // rising side: release once the integral has reached THR_ON
            st_d.drv = st_q.drv | rise_ok;
        end else begin
            // falling side: release once the integral has come down to THR_OFF
            st_d.drv = st_q.drv & ~fall_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv = st_q.drv;

    // R6: immediate rise when the threshold is met
    p_rise_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && int'(cnt) >= THR_ON) |=> drv);

    // R7: held rise keeps its level below THR_ON
    p_rise_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && int'(cnt) < THR_ON) |=> (drv == $past(drv)));

    // R8: immediate fall when the threshold is met
    p_fall_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd && int'(cnt) <= THR_OFF) |=> !drv);

    // R9: held fall keeps its level above THR_OFF
    p_fall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd && int'(cnt) > THR_OFF) |=> (drv == $past(drv)));

endmodule

// File: rtl/dtc_compensator.sv
module dtc_compensator #(
    parameter int        CNT_W   = 16,
    parameter int signed THR_ON  = 0,
    parameter int signed THR_OFF = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_pwm,
    input  logic                    fb_pwm,
    output logic                    gate_cmd,
    output logic signed [CNT_W-1:0] err_level
);

    logic signed [CNT_W-1:0] integ_cnt;

    dtc_error_integrator #(
        .CNT_W (CNT_W)
    ) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd_pwm),
        .fb    (fb_pwm),
        .cnt   (integ_cnt)
    );

    dtc_edge_gate #(
        .CNT_W   (CNT_W),
        .THR_ON  (THR_ON),
        .THR_OFF (THR_OFF)
    ) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd_pwm),
        .cnt   (integ_cnt),
        .drv   (gate_cmd)
    );

    assign err_level = integ_cnt;

    // R1: reset state of both outputs
    p_reset_r1: assert property (@(posedge clk)
        (!rst_n) |-> (!gate_cmd && err_level == '0));

    // R10: the command only falls while low and only rises while high
    p_no_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pwm && !gate_cmd) |=> !gate_cmd);
    p_no_fall_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pwm && gate_cmd) |=> gate_cmd);

endmodule

// File: tb/dtc_compensator_tb.sv
module dtc_compensator_tb;

    localparam int CNT_W   = 6;
    localparam int THR_ON  = -3;
    localparam int THR_OFF = 4;
    localparam int LIM_HI  = (1 << (CNT_W - 1)) - 1;
    localparam int LIM_LO  = -(1 << (CNT_W - 1));
    localparam int D_ON    = 3;
    localparam int D_OFF   = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cmd_pwm = 1'b0;
    logic                    fb_pwm = 1'b0;
    logic                    gate_cmd;
    logic signed [CNT_W-1:0] err_level;

    int    total = 0;
    int    bad = 0;
    int    cnt_m = 0;
    int    c_m = 0;
    int    b_pl = 0;
    int    run_pl = 0;
    string tag_cnt = "R1";
    string tag_c = "R1";

    always #2 clk = ~clk;

    dtc_compensator #(
        .CNT_W   (CNT_W),
        .THR_ON  (THR_ON),
        .THR_OFF (THR_OFF)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_pwm   (cmd_pwm),
        .fb_pwm    (fb_pwm),
        .gate_cmd  (gate_cmd),
        .err_level (err_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the present outputs, apply new inputs, then predict the next edge.
    task automatic cycle(input int a, input int b);
        @(negedge clk);
        check(tag_cnt, int'(err_level), cnt_m);
        check(tag_c, int'(gate_cmd), c_m);
        cmd_pwm = a[0];
        fb_pwm  = b[0];
        if (a == 1) begin
            if (cnt_m >= THR_ON) begin
                c_m = 1;
                tag_c = "R6";
            end else begin
                tag_c = "R7";
            end
        end else begin
            if (cnt_m <= THR_OFF) begin
                c_m = 0;
                tag_c = "R8";
            end else begin
                tag_c = "R9";
            end
        end
        if (a == 1 && b == 0) begin
            if (cnt_m == LIM_HI) tag_cnt = "R5";
            else begin
                cnt_m++;
                tag_cnt = "R2";
            end
        end else if (a == 0 && b == 1) begin
            if (cnt_m == LIM_LO) tag_cnt = "R5";
            else begin
                cnt_m--;
                tag_cnt = "R3";
            end
        end else begin
            tag_cnt = "R4";
        end
    endtask

    // Feedback follows the corrected command with unequal delays.
    task automatic plant_cycle(input int a);
        if (c_m != b_pl) begin
            run_pl++;
            if (run_pl >= ((c_m == 1) ? D_ON : D_OFF)) begin
                b_pl = c_m;
                run_pl = 0;
            end
        end else begin
            run_pl = 0;
        end
        cycle(a, b_pl);
    endtask

    task automatic pulse(input int hi, input int lo);
        for (int i = 0; i < hi; i++) plant_cycle(1);
        for (int i = 0; i < lo; i++) plant_cycle(0);
    endtask

    initial begin
        #(4 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(err_level), 0);
        check("R1", int'(gate_cmd), 0);
        rst_n = 1'b1;
        tag_cnt = "R1";
        tag_c = "R1";
        // R2/R5: climb to and hold at the upper limit
        for (int i = 0; i < 40; i++) cycle(1, 0);
        // R4: equal inputs, both levels
        for (int i = 0; i < 5; i++) cycle(1, 1);
        for (int i = 0; i < 5; i++) cycle(0, 0);
        // R3/R5: fall to and hold at the lower limit
        for (int i = 0; i < 75; i++) cycle(0, 1);
        // R7: held rise from below THR_ON, then release (R6)
        for (int i = 0; i < 40; i++) cycle(1, 0);
        // R9: held fall above THR_OFF, then release (R8)
        for (int i = 0; i < 12; i++) cycle(0, 0);
        for (int i = 0; i < 40; i++) cycle(0, 1);
        // closed-loop operation with wide and short pulses (R10)
        b_pl = 0;
        run_pl = 0;
        for (int i = 0; i < 10; i++) cycle(0, 0);
        pulse(20, 15);
        pulse(12, 12);
        pulse(6, 10);
        pulse(2, 8);
        pulse(1, 6);
        pulse(2, 6);
        pulse(1, 30);
        pulse(30, 4);
        pulse(1, 1);
        pulse(3, 20);
        // random direct patterns
        for (int i = 0; i < 400; i++) cycle(int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
        // random closed-loop pulses
        for (int i = 0; i < 60; i++) pulse(int'($urandom_range(12, 1)), int'($urandom_range(12, 1)));
        @(negedge clk);
        check(tag_cnt, int'(err_level), cnt_m);
        check(tag_c, int'(gate_cmd), c_m);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule